// File: doc/BRIEF.md
# Bus-Master Disk DMA Control and Status Registers

This block is the register set that software uses to steer a bus-master disk DMA engine. Software reaches it through a small byte-wide register window. Three registers live there. The command register carries a run bit and a transfer-direction bit. The status register mixes three kinds of bit: drive capability flags, sticky completion and error flags, and live engine state. The last register is a 32-bit base pointer to the descriptor table in memory. The transfer engine itself is outside this block. It sends back a one-cycle completion pulse, a one-cycle error pulse, an active level and a two-bit phase code. The block returns the run bit, the direction bit and the table base to it.

A driver sets up a transfer in a fixed order. It loads the table pointer, writes the direction, clears stale flags by writing back the status it just read, and then sets the run bit. To finish, it clears the run bit with a read-modify-write. The block also produces a level interrupt and a ready-made completion verdict. It raises a defer flag while the engine reports that it is still mid-transfer, so a watchdog in software can hold off.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every register bit is zero, all outputs are low and every offset reads 0x00.
- R2: Status offset 2, bits 5 and 6, are capability flags for drive 0 and drive 1. Writes set them to the written value and reads return them.
- R3: Status bit 2 (completion flag) is set by a completion pulse and bit 1 (error flag) by an error pulse. Each stays set until a status write with a 1 in its position clears it. A 0 written there has no effect, and a pulse in the same cycle as a clearing write leaves the flag set.
- R4: Writing back a value read from status with bits 1 and 2 forced to 1 clears both flags and leaves the capability bits unchanged.
- R5: Command offset 0, bit 0, is the run bit, driven on `xfer_go`. Writing the read value with bit 0 cleared stops the engine and keeps the other command bits.
- R6: Command bit 3 is the direction bit, driven on `xfer_to_mem`. A 1 means drive-to-memory and a 0 means memory-to-drive.
- R7: Status bit 0 shows the engine active input one cycle later. Writes to it have no effect.
- R8: `xfer_ok` is high exactly when, of status bits 0, 1 and 2, only bit 2 is set.
- R9: Status bits 3 and 4 show the engine phase code one cycle later, are read-only, and `defer_timeout` is high exactly when both are set.
- R10: Offsets 4 to 7 hold the table base pointer, least significant byte at offset 4. Each byte is writable and readable, and the pointer is driven on `tbl_base`.
- R11: `irq` is high exactly while the completion flag is set.
- R12: Offsets 1 and 3 and status bit 7 read as zero, and writes to offsets 1 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset in the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_err | input | 1 | One-cycle error pulse from the engine |
| eng_active | input | 1 | Engine is moving data |
| eng_phase | input | 2 | Engine phase code |
| xfer_go | output | 1 | Run bit to the engine |
| xfer_to_mem | output | 1 | Direction bit to the engine |
| tbl_base | output | 32 | Descriptor table base pointer |
| irq | output | 1 | Level interrupt |
| xfer_ok | output | 1 | Completion verdict |
| defer_timeout | output | 1 | Engine still busy, hold off any timeout |

## Verification
The hardest case to reach from the ports is the collision: an engine pulse in the same cycle as a software write that clears the same flag. The set must win there, and the other flag and the capability bits must not move. The stimulus creates this case on purpose for both flags. It also repeats the driver's write-back of the value just read with the two flag bits forced to 1. A long random phase then mixes writes to every offset with sparse pulses, and a reference model in the bench compares every output on every cycle.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;
    localparam int NUM_DRV = 2;
    localparam int PH_W    = 2;

    localparam logic [ADDR_W-1:0] OFS_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_TBL  = 3'd4;

    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 3;

    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_INT  = 2;
    localparam int ST_PH0  = 3;
    localparam int ST_CAP0 = ST_PH0 + PH_W;

    typedef struct packed {
        logic [NUM_DRV-1:0] cap;
        logic [PH_W-1:0]    ph;
        logic               intr;
        logic               err;
        logic               act;
    } stat_t;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              go,
    output logic              dir,
    output logic [DATA_W-1:0] rd_byte
);
    typedef struct packed {
        logic go;
        logic dir;
    } cmd_t;

    cmd_t cmd_d, cmd_q;
    logic hit;

    assign hit = wr_en && (addr == OFS_CMD);

    always_comb begin
        cmd_d = cmd_q;
        if (hit) begin
            cmd_d.go  = wdata[CMD_GO];
            cmd_d.dir = wdata[CMD_DIR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    always_comb begin
        rd_byte = '0;
        if (addr == OFS_CMD) begin
            rd_byte[CMD_GO]  = cmd_q.go;
            rd_byte[CMD_DIR] = cmd_q.dir;
        end
    end

    assign go  = cmd_q.go;
    assign dir = cmd_q.dir;

    p_go_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(go));
    p_dir_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (dir == $past(wdata[CMD_DIR])));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
    import bmdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ev_done,
    input  logic              ev_err,
    input  logic              ev_active,
    input  logic [PH_W-1:0]   ev_phase,
    output stat_t             st,
    output logic [DATA_W-1:0] rd_byte
);
    stat_t st_d, st_q;
    logic  hit;

    assign hit = wr_en && (addr == OFS_STAT);

    always_comb begin
        st_d     = st_q;
        st_d.act = ev_active;
        st_d.ph  = ev_phase;
        if (hit) begin
            for (int i = 0; i < NUM_DRV; i++) begin
                st_d.cap[i] = wdata[ST_CAP0 + i];
            end
            if (wdata[ST_INT]) st_d.intr = 1'b0;
            if (wdata[ST_ERR]) st_d.err  = 1'b0;
        end
        if (ev_done) st_d.intr = 1'b1;
        if (ev_err)  st_d.err  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_byte = '0;
        if (addr == OFS_STAT) begin
            rd_byte[ST_ACT] = st_q.act;
            rd_byte[ST_ERR] = st_q.err;
            rd_byte[ST_INT] = st_q.intr;
            for (int i = 0; i < PH_W; i++) begin
                rd_byte[ST_PH0 + i] = st_q.ph[i];
            end
            for (int i = 0; i < NUM_DRV; i++) begin
                rd_byte[ST_CAP0 + i] = st_q.cap[i];
            end
        end
    end

    assign st = st_q;

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> st_q.intr);
    p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> st_q.err);
    p_intr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.intr && !(hit && wdata[ST_INT])) |=> st_q.intr);
    p_intr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wdata[ST_INT] && !ev_done) |=> !st_q.intr);
    p_cap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(st_q.cap));
    p_act_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_active |=> st_q.act);
    p_act_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_active |=> !st_q.act);
endmodule

// File: rtl/bmdma_tbl_reg.sv
module bmdma_tbl_reg
    import bmdma_pkg::*;
#(
    parameter int PTR_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [PTR_BYTES*DATA_W-1:0] base,
    output logic [DATA_W-1:0]           rd_byte
);
    localparam int PTR_W = PTR_BYTES * DATA_W;

    logic [PTR_W-1:0]     base_d, base_q;
    logic [PTR_BYTES-1:0] sel;

    for (genvar g = 0; g < PTR_BYTES; g++) begin : g_lane
        assign sel[g] = (addr == OFS_TBL + ADDR_W'(g));
    end

    always_comb begin
        base_d = base_q;
        for (int i = 0; i < PTR_BYTES; i++) begin
            if (wr_en && sel[i]) base_d[i*DATA_W +: DATA_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < PTR_BYTES; i++) begin
            if (sel[i]) rd_byte = base_q[i*DATA_W +: DATA_W];
        end
    end

    assign base = base_q;

    p_tbl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (|sel)) |=> $stable(base));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int PTR_BYTES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        eng_done,
    input  logic                        eng_err,
    input  logic                        eng_active,
    input  logic [PH_W-1:0]             eng_phase,
    output logic                        xfer_go,
    output logic                        xfer_to_mem,
    output logic [PTR_BYTES*DATA_W-1:0] tbl_base,
    output logic                        irq,
    output logic                        xfer_ok,
    output logic                        defer_timeout
);
    stat_t             st;
    logic [DATA_W-1:0] cmd_rd, stat_rd, tbl_rd;

    bmdma_cmd_reg i_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .go      (xfer_go),
        .dir     (xfer_to_mem),
        .rd_byte (cmd_rd)
    );

    bmdma_stat_reg i_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .ev_done   (eng_done),
        .ev_err    (eng_err),
        .ev_active (eng_active),
        .ev_phase  (eng_phase),
        .st        (st),
        .rd_byte   (stat_rd)
    );

    bmdma_tbl_reg #(.PTR_BYTES(PTR_BYTES)) i_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .base    (tbl_base),
        .rd_byte (tbl_rd)
    );

    assign bus_rdata     = cmd_rd | stat_rd | tbl_rd;
    assign irq           = st.intr;
    assign xfer_ok       = st.intr && !st.err && !st.act;
    assign defer_timeout = &st.ph;

    p_irq_follows_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> irq);
    p_ok_needs_intr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> !xfer_ok);
    p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd1 || bus_addr == 3'd3) |-> (bus_rdata == '0));
endmodule

// File: tb/test_bmdma_regs.sv
module test_bmdma_regs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_active = 1'b0;
    logic [1:0]  eng_phase = '0;
    logic        xfer_go, xfer_to_mem, irq, xfer_ok, defer_timeout;
    logic [31:0] tbl_base;

    int vectors = 0;
    int fails = 0;
    bit done_flag = 0;

    // reference state
    logic        m_go, m_dir, m_int, m_err, m_act;
    logic [1:0]  m_cap, m_ph;
    logic [31:0] m_tbl;

    always #(CLK_P/2) clk = ~clk;

    bmdma_regs i_bmdma_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
        .eng_err(eng_err), .eng_active(eng_active), .eng_phase(eng_phase),
        .xfer_go(xfer_go), .xfer_to_mem(xfer_to_mem), .tbl_base(tbl_base),
        .irq(irq), .xfer_ok(xfer_ok), .defer_timeout(defer_timeout)
    );

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return {4'b0, m_dir, 2'b0, m_go};
            3'd2:    return {1'b0, m_cap, m_ph, m_int, m_err, m_act};
            3'd4:    return m_tbl[7:0];
            3'd5:    return m_tbl[15:8];
            3'd6:    return m_tbl[23:16];
            3'd7:    return m_tbl[31:24];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_go = 0; m_dir = 0; m_int = 0; m_err = 0; m_act = 0;
        m_cap = 0; m_ph = 0; m_tbl = 0;
    endtask

    task automatic check_outs();
        chk("R5 xfer_go", 32'(xfer_go), 32'(m_go));
        chk("R6 xfer_to_mem", 32'(xfer_to_mem), 32'(m_dir));
        chk("R10 tbl_base", tbl_base, m_tbl);
        chk("R11 irq", 32'(irq), 32'(m_int));
        chk("R8 xfer_ok", 32'(xfer_ok), 32'(m_int && !m_err && !m_act));
        chk("R9 defer_timeout", 32'(defer_timeout), 32'(m_ph == 2'b11));
    endtask

    // one clock: drive at negedge, check read, step model, check outputs
    task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] wd,
                       input logic dn, input logic er, input logic ac,
                       input logic [1:0] ph, input string tag);
        bus_wr = w; bus_addr = a; bus_wdata = wd;
        eng_done = dn; eng_err = er; eng_active = ac; eng_phase = ph;
        #1;
        chk(tag, 32'(bus_rdata), 32'(m_read(a)));
        @(posedge clk);
        if (w && a == 3'd0) begin m_go = wd[0]; m_dir = wd[3]; end
        if (w && a == 3'd2) begin
            m_cap = wd[6:5];
            if (wd[2]) m_int = 0;
            if (wd[1]) m_err = 0;
        end
        if (w && a == 3'd4) m_tbl[7:0]   = wd;
        if (w && a == 3'd5) m_tbl[15:8]  = wd;
        if (w && a == 3'd6) m_tbl[23:16] = wd;
        if (w && a == 3'd7) m_tbl[31:24] = wd;
        if (dn) m_int = 1;
        if (er) m_err = 1;
        m_act = ac; m_ph = ph;
        @(negedge clk);
        check_outs();
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        cyc(0, a, 8'h00, 0, 0, m_act, m_ph, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        cyc(1, a, d, 0, 0, m_act, m_ph, tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done_flag) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        check_outs();
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a); #1;
            chk("R1 reset read", 32'(bus_rdata), 32'h0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R10: table pointer bytes
        wr(3'd4, 8'h10, "R10 tbl wr");
        wr(3'd5, 8'h32, "R10 tbl wr");
        wr(3'd6, 8'h54, "R10 tbl wr");
        wr(3'd7, 8'h86, "R10 tbl wr");
        chk("R10 base", tbl_base, 32'h86543210);
        for (int a = 4; a < 8; a++) rd(3'(a), "R10 tbl rd");

        // R2: capability bits
        wr(3'd2, 8'h60, "R2 cap wr");
        rd(3'd2, "R2 cap both");
        chk("R2 cap value", 32'(bus_rdata), 32'h60);
        wr(3'd2, 8'h20, "R2 cap wr");
        rd(3'd2, "R2 cap drive0 only");

        // R5/R6: run and direction
        wr(3'd0, 8'h09, "R5 cmd wr");
        chk("R5 go set", 32'(xfer_go), 32'h1);
        chk("R6 to_mem set", 32'(xfer_to_mem), 32'h1);
        rd(3'd0, "R5 cmd rd");
        wr(3'd0, m_read(3'd0) & 8'hFE, "R5 rmw stop");
        chk("R5 go cleared", 32'(xfer_go), 32'h0);
        chk("R5 dir kept", 32'(xfer_to_mem), 32'h1);
        wr(3'd0, 8'h01, "R6 to drive");
        chk("R6 to_mem clear", 32'(xfer_to_mem), 32'h0);

        // R3/R8/R11: completion
        cyc(0, 3'd2, 0, 1, 0, 0, 2'b00, "R3 done pulse");
        chk("R11 irq set", 32'(irq), 32'h1);
        chk("R8 ok", 32'(xfer_ok), 32'h1);
        rd(3'd2, "R3 sticky intr");
        // R7: active, write to bit0 ignored
        cyc(0, 3'd2, 0, 0, 0, 1, 2'b00, "R7 active");
        chk("R8 ok with active", 32'(xfer_ok), 32'h0);
        cyc(1, 3'd2, 8'h21, 0, 0, 0, 2'b00, "R7 write bit0");
        rd(3'd2, "R7 active follows input");
        // error
        cyc(0, 3'd2, 0, 0, 1, 0, 2'b00, "R3 err pulse");
        chk("R8 ok with err", 32'(xfer_ok), 32'h0);
        // writing zeros keeps flags
        wr(3'd2, 8'h20, "R3 zero write");
        rd(3'd2, "R3 flags kept");
        chk("R3 flags kept", 32'(bus_rdata & 8'h06), 32'h06);
        // R4: write back with flags forced
        rd(3'd2, "R4 read");
        wr(3'd2, m_read(3'd2) | 8'h06, "R4 write back");
        rd(3'd2, "R4 after");
        chk("R4 value", 32'(bus_rdata), 32'h20);
        // collision: set wins
        cyc(0, 3'd2, 0, 1, 1, 0, 2'b00, "R3 set both");
        cyc(1, 3'd2, 8'h26, 1, 0, 0, 2'b00, "R3 collide intr");
        chk("R3 intr kept", 32'(irq), 32'h1);
        rd(3'd2, "R3 err cleared");
        chk("R3 err cleared", 32'(bus_rdata & 8'h06), 32'h04);
        cyc(1, 3'd2, 8'h26, 0, 1, 0, 2'b00, "R3 collide err");
        rd(3'd2, "R3 err kept");
        chk("R3 err kept", 32'(bus_rdata & 8'h06), 32'h02);

        // R9: phase
        cyc(0, 3'd2, 0, 0, 0, 0, 2'b11, "R9 phase busy");
        chk("R9 defer", 32'(defer_timeout), 32'h1);
        cyc(1, 3'd2, 8'h38, 0, 0, 0, 2'b01, "R9 phase write");
        chk("R9 defer off", 32'(defer_timeout), 32'h0);
        rd(3'd2, "R9 phase ro");

        // R12: unused offsets
        wr(3'd1, 8'hFF, "R12 wr1");
        wr(3'd3, 8'hFF, "R12 wr3");
        rd(3'd1, "R12 rd1");
        rd(3'd3, "R12 rd3");
        for (int a = 0; a < 8; a++) rd(3'(a), "R12 others kept");

        // random mix
        for (int n = 0; n < 2000; n++) begin
            automatic logic w  = ($urandom % 3) == 0;
            automatic logic [2:0] a = 3'($urandom);
            automatic logic [7:0] d = 8'($urandom);
            automatic logic dn = ($urandom % 9) == 0;
            automatic logic er = ($urandom % 13) == 0;
            automatic logic ac = 1'($urandom);
            automatic logic [1:0] ph = 2'($urandom);
            string tg;
            tg = (a == 3'd0) ? "R5 rand cmd" : (a == 3'd2) ? "R3 rand stat" :
                 (a >= 3'd4) ? "R10 rand tbl" : "R12 rand unused";
            cyc(w, a, d, dn, er, ac, ph, tg);
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule